// File: doc/BRIEF.md
# Bridge Primary-Side Parity Error Reporter

This block keeps the primary-side parity error status of a PCI-to-PCI bridge and decides when the bridge raises its system error output. Elsewhere in the bridge, the parity checkers and bus sequencers present parity faults as single-cycle events. This block only classifies those events and records them. It does not compute parity.

A general event carries three fields: the transaction kind, the direction, and the bus that saw the fault. The block uses these fields to decide whether the primary detected-parity flag is set. A second event reports that the target on the primary bus signalled a parity fault during an upstream write. That event can set the data-parity flag and, under four joint conditions, the signalled-system-error flag and a one-clock active-low system error pulse.

All three flags are sticky. Software clears a flag by writing 1 to its bit through a small clear port.

Top module: `pbr_report_top`

## Requirements
- R1: A general event detected on the primary bus (bus code 0) sets status bit 0 (detected parity) in three cases: an upstream (dir 1) read (kind 0), a downstream (dir 0) posted write (kind 1), or a downstream delayed write (kind 2). A downstream read, an upstream posted write, an upstream delayed write and kind code 3 leave bit 0 unchanged.
- R2: A general event detected on the secondary bus (bus code 1) never sets status bit 0, whatever its kind, direction or forwarded flag.
- R3: Whether status bit 0 is set does not depend on `pri_perr_en`, `sec_perr_en` or `serr_en`.
- R4: A target-fault event (`tperr_valid`) sets status bit 1 (data parity detected) only when `pri_perr_en` is 1.
- R5: A target-fault event sets status bit 2 (signalled system error) and drives `serr_n` low only when all four of the following hold:
  - `serr_en` is 1;
  - `sec_perr_en` is 1;
  - `pri_perr_en` is 1;
  - `tperr_fwd` is 0.
- R6: A target-fault event with `tperr_fwd` = 1 never drives `serr_n` low or sets bit 2, even with every enable at 1. General events never drive `serr_n`.
- R7: Status bits hold until a cycle with `clr_we` = 1 and a 1 in the matching bit of `clr_data`. When a set and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: `serr_n` is low for exactly the one clock after each qualifying event. It stays low on consecutive clocks when qualifying events arrive on consecutive cycles.
- R9: While `rst_n` is 0 at a rising clock edge, all status bits clear and `serr_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | General parity event strobe |
| evt_kind | input | 2 | Transaction kind: 0 read, 1 posted write, 2 delayed write, 3 reserved |
| evt_dir | input | 1 | Direction: 0 downstream, 1 upstream |
| evt_bus | input | 1 | Detecting bus: 0 primary, 1 secondary |
| evt_fwd | input | 1 | Fault was carried over from the other bus |
| tperr_valid | input | 1 | Primary target signalled a parity fault during an upstream write |
| tperr_fwd | input | 1 | That fault was forwarded from the secondary bus |
| serr_en | input | 1 | System error enable, primary command |
| pri_perr_en | input | 1 | Parity response enable, primary command |
| sec_perr_en | input | 1 | Parity response enable, secondary bridge control |
| clr_we | input | 1 | Status clear strobe |
| clr_data | input | 3 | Write-1-to-clear mask for the status bits |
| status | output | 3 | bit 0 detected parity, bit 1 data parity detected, bit 2 signalled system error |
| serr_n | output | 1 | Active-low system error pulse |

## Verification
Two situations are hard to reach from the ports. The first is a set and a clear of the same bit in the same cycle. The second is two qualifying target-fault events on adjacent clocks, which must hold `serr_n` low with no high gap between them. The bench reaches both with dedicated directed steps. The rest of the bench sweeps every kind, direction, bus and forwarded combination against all eight enable patterns. It also sweeps all sixteen combinations of enables and forwarded flag for target-fault events. Before every event it clears the flags, so that each result is caused by that event alone.

// File: rtl/pbr_pkg.sv
// Package: shared encodings and status layout for the parity error reporter.
// Assumes: the event producers use exactly these code values.
package pbr_pkg;

    // Transaction kind carried with a general parity event.
    typedef enum logic [1:0] {
        XK_READ    = 2'd0,
        XK_POSTED  = 2'd1,
        XK_DELAYED = 2'd2,
        XK_RSVD    = 2'd3
    } xfer_kind_e;

    // Direction code.
    localparam logic DIR_DOWN = 1'b0;
    localparam logic DIR_UP   = 1'b1;

    // Detecting bus code.
    localparam logic BUS_PRI = 1'b0;
    localparam logic BUS_SEC = 1'b1;

    // Status vector layout.
    localparam int STAT_W = 3;
    localparam int ST_DPE = 0;  // detected parity
    localparam int ST_MDP = 1;  // data parity detected
    localparam int ST_SSE = 2;  // signalled system error

endpackage

// File: rtl/pbr_detect_decode.sv
// Module: classifies a general parity event and tells whether it sets the
// primary detected-parity flag.
// Assumes: inputs are valid only while evt_valid is high. Enables play no part.
module pbr_detect_decode
    import pbr_pkg::*;
(
    input  logic       evt_valid,
    input  logic [1:0] evt_kind,
    input  logic       evt_dir,
    input  logic       evt_bus,
    output logic       dpe_set
);

    xfer_kind_e kind;
    logic       kind_hit;

    // Purpose: decide per kind which direction counts on the primary bus.
    always_comb begin
        kind = xfer_kind_e'(evt_kind);
        unique case (kind)
            XK_READ:    kind_hit = (evt_dir == DIR_UP);
            XK_POSTED:  kind_hit = (evt_dir == DIR_DOWN);
            XK_DELAYED: kind_hit = (evt_dir == DIR_DOWN);
            default:    kind_hit = 1'b0;
        endcase
    end

    // Purpose: only a valid event seen on the primary bus can qualify.
    always_comb begin
        dpe_set = evt_valid && (evt_bus == BUS_PRI) && kind_hit;
    end

endmodule

// File: rtl/pbr_serr_gate.sv
// Module: qualifies a primary target parity fault seen during an upstream
// write. It yields the data-parity set and the system error request.
// Assumes: a single-cycle tperr_valid strobe.
module pbr_serr_gate (
    input  logic tperr_valid,
    input  logic tperr_fwd,
    input  logic serr_en,
    input  logic pri_perr_en,
    input  logic sec_perr_en,
    output logic mdp_set,
    output logic serr_req
);

    logic all_enabled;

    // Purpose: the three enable bits taken together.
    always_comb begin
        all_enabled = serr_en && pri_perr_en && sec_perr_en;
    end

    // Purpose: a forwarded fault was already seen by its initiator, so no system error.
    always_comb begin
        mdp_set  = tperr_valid && pri_perr_en;
        serr_req = tperr_valid && all_enabled && !tperr_fwd;
    end

endmodule

// File: rtl/pbr_sticky_bits.sv
// Module: bank of sticky status flags with write-1-to-clear.
// Assumes: synchronous active-low reset. A set beats a clear in the same cycle.
module pbr_sticky_bits #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] clr_data,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Purpose: hold one flag until it is cleared by software.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else if (set_i[i]) begin
                q[i] <= 1'b1;
            end else if (clr_we && clr_data[i]) begin
                q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pbr_report_top.sv
// Module: primary-side parity error reporter. It joins the event decode, the
// system error gate and the sticky status bank, and registers the active-low
// system error pulse.
// Assumes: events are one-cycle strobes and reset is synchronous active-low.
module pbr_report_top
    import pbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [1:0]        evt_kind,
    input  logic              evt_dir,
    input  logic              evt_bus,
    input  logic              evt_fwd,
    input  logic              tperr_valid,
    input  logic              tperr_fwd,
    input  logic              serr_en,
    input  logic              pri_perr_en,
    input  logic              sec_perr_en,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_data,
    output logic [STAT_W-1:0] status,
    output logic              serr_n
);

    logic              dpe_set;
    logic              mdp_set;
    logic              serr_req;
    logic [STAT_W-1:0] set_vec;
    logic              fwd_unused;

    pbr_detect_decode u_decode (
        .evt_valid (evt_valid),
        .evt_kind  (evt_kind),
        .evt_dir   (evt_dir),
        .evt_bus   (evt_bus),
        .dpe_set   (dpe_set)
    );

    pbr_serr_gate u_gate (
        .tperr_valid (tperr_valid),
        .tperr_fwd   (tperr_fwd),
        .serr_en     (serr_en),
        .pri_perr_en (pri_perr_en),
        .sec_perr_en (sec_perr_en),
        .mdp_set     (mdp_set),
        .serr_req    (serr_req)
    );

    // Purpose: gather per-flag set requests into the status layout.
    always_comb begin
        set_vec         = '0;
        set_vec[ST_DPE] = dpe_set;
        set_vec[ST_MDP] = mdp_set;
        set_vec[ST_SSE] = serr_req;
        fwd_unused      = evt_fwd;  // a general event never drives the system error output
    end

    pbr_sticky_bits #(.WIDTH(STAT_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .clr_we   (clr_we),
        .clr_data (clr_data),
        .q        (status)
    );

    // Purpose: one low clock of the system error output per qualifying event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serr_n <= 1'b1;
        end else begin
            serr_n <= !serr_req;
        end
    end

endmodule

// File: rtl/pbr_report_chk.sv
// Module: property checker for the parity error reporter, bound to the top.
// Assumes: it observes the top-level ports only.
module pbr_report_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       evt_valid,
    input logic [1:0] evt_kind,
    input logic       evt_dir,
    input logic       evt_bus,
    input logic       tperr_valid,
    input logic       tperr_fwd,
    input logic       serr_en,
    input logic       pri_perr_en,
    input logic       sec_perr_en,
    input logic       clr_we,
    input logic [2:0] clr_data,
    input logic [2:0] status,
    input logic       serr_n
);

    // R1
    dpe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(evt_valid && !evt_bus &&
            ((evt_kind == 2'd0 && evt_dir) || ((evt_kind == 2'd1 || evt_kind == 2'd2) && !evt_dir))));

    // R2
    sec_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> !$past(evt_bus));

    // R4
    mdp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> $past(tperr_valid && pri_perr_en));

    // R5
    serr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past(tperr_valid && serr_en && pri_perr_en && sec_perr_en));

    // R6
    serr_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> !$past(tperr_fwd));

    // R5
    serr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> status[2]);

    for (genvar i = 0; i < 3; i++) begin : g_clr
        // R7
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(status[i]) |-> $past(clr_we && clr_data[i]));
    end

    // R9
    reset_state_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (serr_n && status == 3'b000));

endmodule

bind pbr_report_top pbr_report_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_valid   (evt_valid),
    .evt_kind    (evt_kind),
    .evt_dir     (evt_dir),
    .evt_bus     (evt_bus),
    .tperr_valid (tperr_valid),
    .tperr_fwd   (tperr_fwd),
    .serr_en     (serr_en),
    .pri_perr_en (pri_perr_en),
    .sec_perr_en (sec_perr_en),
    .clr_we      (clr_we),
    .clr_data    (clr_data),
    .status      (status),
    .serr_n      (serr_n)
);

// File: tb/pbr_report_top_tb.sv
`timescale 1ns/1ps
// Bench: exhaustive sweeps of general and target-fault events, plus directed
// collision, back-to-back and reset steps. Inputs change on the falling edge;
// outputs are sampled on the falling edge after the capturing rising edge.
module pbr_report_top_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       evt_valid, evt_dir, evt_bus, evt_fwd;
    logic [1:0] evt_kind;
    logic       tperr_valid, tperr_fwd;
    logic       serr_en, pri_perr_en, sec_perr_en;
    logic       clr_we;
    logic [2:0] clr_data;
    logic [2:0] status;
    logic       serr_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pbr_report_top u_dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_dir(evt_dir), .evt_bus(evt_bus), .evt_fwd(evt_fwd),
        .tperr_valid(tperr_valid), .tperr_fwd(tperr_fwd), .serr_en(serr_en),
        .pri_perr_en(pri_perr_en), .sec_perr_en(sec_perr_en), .clr_we(clr_we),
        .clr_data(clr_data), .status(status), .serr_n(serr_n)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle();
        evt_valid = 0; evt_kind = 0; evt_dir = 0; evt_bus = 0; evt_fwd = 0;
        tperr_valid = 0; tperr_fwd = 0; clr_we = 0; clr_data = 0;
    endtask

    // Clear all flags with one write cycle and confirm.
    task automatic clear_all();
        @(negedge clk);
        idle(); clr_we = 1; clr_data = 3'b111;
        @(negedge clk);
        idle();
        check("R7 clear", {1'b0, status}, 4'b0000);
    endtask

    initial begin
        rst_n = 0; idle();
        serr_en = 0; pri_perr_en = 0; sec_perr_en = 0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset", {serr_n, status}, 4'b1000);
        rst_n = 1;

        // R1 R2 R3: sweep of general events against every enable pattern
        for (int k = 0; k < 4; k++)
            for (int d = 0; d < 2; d++)
                for (int b = 0; b < 2; b++)
                    for (int f = 0; f < 2; f++)
                        for (int e = 0; e < 8; e++) begin
                            logic exp0;
                            clear_all();
                            exp0 = (b == 0) && ((k == 0 && d == 1) || ((k == 1 || k == 2) && d == 0));
                            {serr_en, pri_perr_en, sec_perr_en} = 3'(e);
                            evt_valid = 1; evt_kind = 2'(k); evt_dir = d[0];
                            evt_bus = b[0]; evt_fwd = f[0];
                            @(negedge clk);
                            idle();
                            if (b == 1) check("R2 secondary bus", {serr_n, status}, 4'b1000);
                            else        check("R1 R3 primary decode", {serr_n, status}, {1'b1, 2'b00, exp0});
                            @(negedge clk);
                            check("R7 hold", {serr_n, status}, {1'b1, 2'b00, exp0});
                        end

        // R4 R5 R6: target-fault sweep over enables and forwarded flag
        for (int e = 0; e < 16; e++) begin
            logic se, pe, sc, fw, qual;
            clear_all();
            {se, pe, sc, fw} = 4'(e);
            qual = se && pe && sc && !fw;
            serr_en = se; pri_perr_en = pe; sec_perr_en = sc;
            tperr_valid = 1; tperr_fwd = fw;
            @(negedge clk);
            idle();
            check("R4 R5 R6 target fault", {serr_n, status}, {!qual, qual, pe, 1'b0});
            @(negedge clk);
            check("R8 pulse width", {serr_n, status}, {1'b1, qual, pe, 1'b0});
        end

        // R8 back-to-back qualifying events
        clear_all();
        serr_en = 1; pri_perr_en = 1; sec_perr_en = 1;
        tperr_valid = 1;
        @(negedge clk);
        check("R8 first low", {3'b000, serr_n}, 4'b0000);
        @(negedge clk);
        idle();
        check("R8 second low", {3'b000, serr_n}, 4'b0000);
        @(negedge clk);
        check("R8 released", {3'b000, serr_n}, 4'b0001);

        // R7 set wins over a clear in the same cycle
        clear_all();
        evt_valid = 1; evt_kind = 2'd0; evt_dir = 1; evt_bus = 0;
        tperr_valid = 1; clr_we = 1; clr_data = 3'b111;
        @(negedge clk);
        idle();
        check("R7 set wins", {serr_n, status}, 4'b0111);
        // R7 partial clear of bit 1 only
        clr_we = 1; clr_data = 3'b010;
        @(negedge clk);
        idle();
        check("R7 partial clear", {serr_n, status}, 4'b1101);

        // R9 reset clears flags
        rst_n = 0;
        @(negedge clk);
        check("R9 reset clears", {serr_n, status}, 4'b1000);
        rst_n = 1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule